// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog driven by a free-running 64-bit system counter. The counter is supplied as an input. Software arms the block by writing a period and setting the enable bit. From then on the block holds an absolute 64-bit deadline and compares the counter against it on every clock.

The first time the counter passes the deadline, the block raises an interrupt and moves the deadline one period further on. If that second deadline also passes before software refreshes the block, the block raises a reset request. A refresh is a write of any value to the refresh frame. A write to the control/status word or to the period also refreshes the block. A refresh moves the deadline to counter plus period and clears both stage flags.

The second-stage flag survives the ordinary reset it causes, so software can later read why the system restarted. Only a refresh or the power-on reset clears it.

Top module: `wdog_two_stage`

## Requirements
- R1: After power-on reset, the control/status word (control frame, offset 0x000) reads 0, the period (0x008) reads 0, and the deadline (0x010 low word, 0x014 high word) reads 0.
- R2: In the control/status word, bit 0 is enable, bit 1 is the first-stage flag and bit 2 is the second-stage flag. A write sets enable to bit 0 of the written data, so a write of 0 stops the watchdog.
- R3: A write of any data to the refresh frame (bus_frame=1) at offset 0x000 loads the deadline with counter plus period and clears both stage flags.
- R4: A write to the control/status word also refreshes the block in the same way as R3.
- R5: A period write refreshes the block only when it is enabled, and the refresh uses the new period. When the block is disabled, the deadline is left unchanged.
- R6: When the block is enabled, the counter is strictly greater than the deadline and the first-stage flag is clear, then one cycle later the first-stage flag and irq_o are set and the deadline becomes counter plus period. irq_o therefore rises P+1 cycles after a refresh.
- R7: When the block is enabled, the counter is greater than the deadline and the first-stage flag is already set, then one cycle later the second-stage flag and rst_o are set. This happens 2P+2 cycles after a refresh.
- R8: When the block is disabled, no stage flag ever sets, however far the counter has run past the deadline.
- R9: rst_n clears enable, the first-stage flag, the period and the deadline, but it keeps the second-stage flag; rst_o is low after that reset. por_n clears everything, including the second-stage flag.
- R10: The deadline can be written as two 32-bit halves, the low half at 0x010 and the high half at 0x014, and each half reads back as written.
- R11: The interface-ID word (0xFCC) and the part-ID word (0xFD0) read their parameter values, and writes to them have no effect.
- R12: A counter equal to the deadline does not expire a stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Functional reset, active low; keeps the second-stage flag |
| por_n | input | 1 | Power-on reset, active low; clears all state |
| sys_cnt | input | 64 | Free-running system counter |
| bus_req | input | 1 | Write strobe, valid for one cycle |
| bus_wr | input | 1 | 1 = write |
| bus_frame | input | 1 | 0 = control frame, 1 = refresh frame |
| bus_addr | input | ADDR_W | Byte offset within the frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_frame/bus_addr (combinational) |
| irq_o | output | 1 | First-stage interrupt |
| rst_o | output | 1 | Second-stage reset request |

## Verification
A wrong deadline or stage state shows up as an interrupt or reset edge that arrives one or more cycles away from the expected P+1 or 2P+2 count after a refresh. The bench measures that count directly, for random periods. A stage flag that is wrongly set or held shows in the control/status read-back, and it also shows at irq_o or rst_o in the very next cycle. A lost second-stage flag only shows after a functional reset, so the bench reads the flag back across both reset kinds.

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int          ADDR_W   = 12,
  parameter logic [31:0] IFACE_ID = 32'h0001_043B,
  parameter logic [31:0] PART_ID  = 32'h5D0A_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic [63:0]       sys_cnt,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic              bus_frame,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              rst_o
);
  localparam logic [ADDR_W-1:0] OFS_CS    = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] OFS_PER   = ADDR_W'('h008);
  localparam logic [ADDR_W-1:0] OFS_DL_LO = ADDR_W'('h010);
  localparam logic [ADDR_W-1:0] OFS_DL_HI = ADDR_W'('h014);
  localparam logic [ADDR_W-1:0] OFS_IFID  = ADDR_W'('hFCC);
  localparam logic [ADDR_W-1:0] OFS_PID   = ADDR_W'('hFD0);

  logic        en_q, st1_q, st2_q;
  logic [31:0] period_q;
  logic [63:0] deadline_q;

  wire wr     = bus_req & bus_wr;
  wire hit_cs = wr & ~bus_frame & (bus_addr == OFS_CS);
  wire hit_pr = wr & ~bus_frame & (bus_addr == OFS_PER);
  wire hit_lo = wr & ~bus_frame & (bus_addr == OFS_DL_LO);
  wire hit_hi = wr & ~bus_frame & (bus_addr == OFS_DL_HI);
  wire hit_rf = wr &  bus_frame & (bus_addr == OFS_CS);
  wire dl_wr  = hit_lo | hit_hi;
  wire kick   = hit_rf | hit_cs | (hit_pr & en_q);

  wire [31:0] next_period = hit_pr ? bus_wdata : period_q;
  wire [63:0] reload      = sys_cnt + {32'b0, next_period};
  wire        expired     = en_q & (sys_cnt > deadline_q);
  wire        all_rst_n   = rst_n & por_n;

  always_ff @(posedge clk or negedge all_rst_n) begin
    if (!all_rst_n) begin
      en_q       <= 1'b0;
      st1_q      <= 1'b0;
      period_q   <= '0;
      deadline_q <= '0;
    end else begin
      if (hit_cs) en_q <= bus_wdata[0];
      if (hit_pr) period_q <= bus_wdata;
      if (kick) begin
        deadline_q <= reload;
        st1_q      <= 1'b0;
      end else if (dl_wr) begin
        if (hit_lo) deadline_q[31:0]  <= bus_wdata;
        if (hit_hi) deadline_q[63:32] <= bus_wdata;
      end else if (expired && !st1_q) begin
        st1_q      <= 1'b1;
        deadline_q <= reload;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                           st2_q <= 1'b0;
    else if (kick)                        st2_q <= 1'b0;
    else if (!dl_wr && expired && st1_q)  st2_q <= 1'b1;
  end

  assign irq_o = st1_q & en_q;
  assign rst_o = st2_q & en_q;

  always_comb begin
    bus_rdata = '0;
    if (!bus_frame) begin
      unique case (bus_addr)
        OFS_CS:    bus_rdata = {29'b0, st2_q, st1_q, en_q};
        OFS_PER:   bus_rdata = period_q;
        OFS_DL_LO: bus_rdata = deadline_q[31:0];
        OFS_DL_HI: bus_rdata = deadline_q[63:32];
        OFS_IFID:  bus_rdata = IFACE_ID;
        OFS_PID:   bus_rdata = PART_ID;
        default:   bus_rdata = '0;
      endcase
    end
  end

  a_r2_enable_follows: assert property (@(posedge clk) disable iff (!all_rst_n)
    hit_cs |=> en_q == $past(bus_wdata[0]));
  a_r3_refresh_reload: assert property (@(posedge clk) disable iff (!all_rst_n)
    (hit_rf && !hit_pr) |=> (!st1_q && !st2_q &&
      deadline_q == $past(sys_cnt) + {32'b0, $past(period_q)}));
  a_r6_first_stage: assert property (@(posedge clk) disable iff (!all_rst_n)
    (en_q && !st1_q && sys_cnt > deadline_q && !bus_req) |=> irq_o);
  a_r7_second_stage: assert property (@(posedge clk) disable iff (!all_rst_n)
    (en_q && st1_q && sys_cnt > deadline_q && !bus_req) |=> rst_o);
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!all_rst_n)
    (!en_q && !bus_req) |=> ($stable(st1_q) && !irq_o && !rst_o));
endmodule

// File: tb/test_wdog_two_stage.sv
module test_wdog_two_stage;
  localparam logic [31:0] IFID = 32'h0001_043B;
  localparam logic [31:0] PID  = 32'h5D0A_0001;

  logic        clk = 0;
  logic        rst_n = 0, por_n = 0;
  logic [63:0] sys_cnt = 64'h0000_0001_FFFF_FF00;
  logic        bus_req = 0, bus_wr = 0, bus_frame = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, rst_o;

  int checks = 0, fails = 0;
  logic [63:0] last_c;

  wdog_two_stage #(.ADDR_W(12), .IFACE_ID(IFID), .PART_ID(PID)) i_wdog_two_stage (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .sys_cnt(sys_cnt),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_frame(bus_frame),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .rst_o(rst_o));

  always #2.5 clk = ~clk;
  always @(negedge clk) sys_cnt <= sys_cnt + 64'd1;

  function automatic logic [31:0] cs_word(logic en, logic s1, logic s2);
    return {29'b0, s2, s1, en};
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic frame, input logic [11:0] addr, input logic [31:0] data);
    @(negedge clk);
    bus_req = 1; bus_wr = 1; bus_frame = frame; bus_addr = addr; bus_wdata = data;
    @(posedge clk);
    last_c = sys_cnt;
    #1 bus_req = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] addr, output logic [31:0] d);
    bus_frame = 0; bus_addr = addr;
    #0.5 d = bus_rdata;
  endtask

  task automatic rd_dl(output logic [63:0] d);
    logic [31:0] lo, hi;
    rd(12'h010, lo); rd(12'h014, hi);
    d = {hi, lo};
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] dl, dl0;
    int p;
    void'($urandom(32'd20240611));
    #12 por_n = 1; rst_n = 1;
    @(posedge clk); #1;
    rd(12'h000, d); check(d == 0, "R1 cs", d, 0);
    rd(12'h008, d); check(d == 0, "R1 period", d, 0);
    rd_dl(dl);      check(dl == 0, "R1 deadline", dl, 0);

    edges(20);
    check(!irq_o && !rst_o, "R8 disabled no expiry", {irq_o, rst_o}, 0);
    rd(12'h000, d); check(d == 0, "R8 flags clear", d, 0);

    wr(0, 12'h010, 32'hDEAD_0010); wr(0, 12'h014, 32'h0000_0077);
    rd_dl(dl); check(dl == 64'h0000_0077_DEAD_0010, "R10 deadline halves", dl, 64'h0000_0077_DEAD_0010);
    wr(0, 12'h008, 32'd9);
    rd_dl(dl0); check(dl0 == 64'h0000_0077_DEAD_0010, "R5 disabled period write no refresh", dl0, 64'h0000_0077_DEAD_0010);

    rd(12'hFCC, d); check(d == IFID, "R11 iface id", d, IFID);
    rd(12'hFD0, d); check(d == PID, "R11 part id", d, PID);
    wr(0, 12'hFCC, 32'h1234_5678); wr(0, 12'hFD0, 32'h0);
    rd(12'hFCC, d); check(d == IFID, "R11 iface id after write", d, IFID);
    rd(12'hFD0, d); check(d == PID, "R11 part id after write", d, PID);

    for (int it = 0; it < 8; it++) begin
      p = $urandom_range(3, 24);
      wr(0, 12'h008, 32'(p));
      wr(0, 12'h000, 32'h1);
      rd_dl(dl); check(dl == last_c + 64'(p), "R4 cs write reload", dl, last_c + 64'(p));
      rd(12'h000, d); check(d == cs_word(1, 0, 0), "R2 enable set", d, cs_word(1, 0, 0));
      edges(p);
      check(!irq_o, "R12 equal does not expire", irq_o, 0);
      edges(1);
      check(irq_o && !rst_o, "R6 first stage at P+1", {irq_o, rst_o}, 2'b10);
      rd_dl(dl); check(dl == last_c + 64'(2 * p + 1), "R6 deadline advanced", dl, last_c + 64'(2 * p + 1));
      case ($urandom_range(0, 2))
        0: begin
          wr(1, 12'h000, $urandom);
          rd(12'h000, d); check(d == cs_word(1, 0, 0), "R3 refresh clears stage", d, cs_word(1, 0, 0));
          rd_dl(dl); check(dl == last_c + 64'(p), "R3 refresh reload", dl, last_c + 64'(p));
        end
        1: begin
          wr(0, 12'h008, 32'(p + 5));
          rd_dl(dl); check(dl == last_c + 64'(p + 5), "R5 enabled period write refresh", dl, last_c + 64'(p + 5));
          check(!irq_o, "R5 stage cleared", irq_o, 0);
        end
        default: begin
          edges(p);
          check(!rst_o, "R7 no reset before 2P+2", rst_o, 0);
          edges(1);
          check(rst_o, "R7 second stage", rst_o, 1);
          rd(12'h000, d); check(d == cs_word(1, 1, 1), "R7 status", d, cs_word(1, 1, 1));
        end
      endcase
      wr(0, 12'h000, 32'h0);
      rd(12'h000, d); check(d == 0, "R2 write 0 stops", d, 0);
    end

    wr(0, 12'h008, 32'd4); wr(0, 12'h000, 32'h1);
    edges(12);
    check(rst_o, "R7 reset reached", rst_o, 1);
    @(negedge clk) rst_n = 0;
    @(negedge clk) rst_n = 1;
    #1;
    rd(12'h000, d); check(d == cs_word(0, 0, 1), "R9 second flag kept", d, cs_word(0, 0, 1));
    check(!rst_o && !irq_o, "R9 outputs low after reset", {irq_o, rst_o}, 0);
    rd(12'h008, d); check(d == 0, "R9 period cleared", d, 0);
    @(negedge clk) por_n = 0;
    @(negedge clk) por_n = 1;
    #1;
    rd(12'h000, d); check(d == 0, "R9 por clears all", d, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule